// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This block turns one 128-bit plaintext block into its AES-128 ciphertext in electronic-codebook fashion, computing one cipher round per clock. Before any data is processed the caller loads a 128-bit key. A ten-cycle expansion phase builds all eleven round keys and keeps them in registers, and every later encryption uses them until another key is loaded.

Key loading and encryption each have their own request strobe, busy flag and one-cycle done pulse. Only one operation runs at a time, and a request that arrives while either operation is running is dropped without any effect. Each block takes a fixed eleven cycles from its accepting clock edge to a one-cycle ciphertext strobe. A caller that raises the next request in the cycle after the done pulse gets encryptions with no idle cycles between them.

Top module: `aes128_enc_iter`

## Requirements
- R1: A `key_valid` sampled high while both busy flags are low starts key loading. `key_busy` is high for exactly the 10 cycles that follow the accepting edge, and `key_done` is high only in the last of them.
- R2: `key_in` is captured on the accepting edge. Changing it afterwards does not change the result of later encryptions.
- R3: While `key_busy` or `blk_busy` is high, `key_valid` and `blk_valid` are ignored: no busy flag rises and no stored key or block changes.
- R4: If `key_valid` and `blk_valid` are both high in an idle cycle, the key load wins and the block request is dropped.
- R5: A `blk_valid` sampled high while both busy flags are low starts an encryption. `blk_busy` is high for exactly the 10 cycles that follow the accepting edge, and `blk_done` is high only in the last of them.
- R6: In the 11th cycle after the accepting edge, `ct_valid` is high and `ct_out` holds the AES-128 ciphertext. Reference results: key 000102030405060708090a0b0c0d0e0f with plaintext 00112233445566778899aabbccddeeff gives 69c4e0d86a7b0430d8cdb78070b4c55a. Key 2b7e151628aed2a6abf7158809cf4f3c with plaintext 3243f6a8885a308d313198a2e0370734 gives 3925841d02dc09fbdc118597196a0b32.
- R7: A `blk_valid` raised in the cycle right after `blk_done` is accepted, so blocks can run back to back with no idle cycle.
- R8: A loaded key stays in use for every following encryption until a new key load is accepted.
- R9: `ct_valid` lasts one cycle. `ct_out` holds its value until the next encryption completes.
- R10: An encryption requested before any key load uses the all-zero key. A zero plaintext then gives 66e94bd4ef8a2c3b884cfa59ca342b2e.
- R11: `rst_n` is active low. After reset, all busy, done and valid outputs are low and `ct_out` is zero.
- R12: `blk_in` is captured on the accepting edge. Changing it afterwards does not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid | input | 1 | Key load request |
| key_in | input | 128 | Key to load |
| key_busy | output | 1 | Key expansion in progress |
| key_done | output | 1 | Last cycle of key expansion |
| blk_valid | input | 1 | Encryption request |
| blk_in | input | 128 | Plaintext block |
| blk_busy | output | 1 | Encryption in progress |
| blk_done | output | 1 | Last cycle of encryption |
| ct_valid | output | 1 | One-cycle ciphertext strobe |
| ct_out | output | 128 | Ciphertext, held until the next result |

## Verification
The bench changes `key_in` and `blk_in` while an operation is running, and keeps requests high during busy periods. A design that sampled its inputs late, or accepted requests while busy, would return a wrong ciphertext or show a busy flag out of turn. It encrypts before any key load, which catches a reset key schedule that is all zeros instead of the expanded zero key. It also issues a request in the cycle right after a done pulse, and raises key and block requests together. These catch a done pulse that is off by one cycle and a missing priority rule: the back-to-back block would be lost, or both operations would start at once. The bench also checks that the ciphertext stays stable across a later key load, which exposes an output register that is not held.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;
  localparam int BLK_W  = 128;
  localparam int NR     = 10;
  localparam int CNT_W  = $clog2(NR + 1);
  localparam int NBYTES = BLK_W / 8;

  typedef logic [NR:0][BLK_W-1:0] sched_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // multiplicative inverse as x^254, then the affine map
  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] pw;
    logic [7:0] inv;
    pw  = x;
    inv = 8'h01;
    for (int i = 1; i < 8; i++) begin
      pw  = gf_mul(pw, pw);
      inv = gf_mul(inv, pw);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [31:0] sub_word(input logic [31:0] w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

  function automatic logic [BLK_W-1:0] key_step(input logic [BLK_W-1:0] k,
                                                input logic [7:0] rc);
    logic [31:0] t, n0, n1, n2, n3;
    t  = sub_word({k[23:0], k[31:24]}) ^ {rc, 24'h000000};
    n0 = k[127:96] ^ t;
    n1 = k[95:64]  ^ n0;
    n2 = k[63:32]  ^ n1;
    n3 = k[31:0]   ^ n2;
    return {n0, n1, n2, n3};
  endfunction

  function automatic sched_t expand_key(input logic [BLK_W-1:0] k);
    sched_t s;
    logic [7:0] rc;
    s[0] = k;
    rc   = 8'h01;
    for (int i = 1; i <= NR; i++) begin
      s[i] = key_step(s[i-1], rc);
      rc   = xtime(rc);
    end
    return s;
  endfunction
endpackage

// File: rtl/aes_round.sv
module aes_round
  import aes_enc_pkg::*;
(
  input  logic [BLK_W-1:0] st_in,
  input  logic [BLK_W-1:0] rk_in,
  input  logic             final_rnd,
  output logic [BLK_W-1:0] st_out
);
  logic [BLK_W-1:0] sr_v;
  logic [BLK_W-1:0] mc_v;

  // substitution fused with the row rotation
  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      localparam int DST = 4 * c + r;
      localparam int SRC = 4 * ((c + r) % 4) + r;
      assign sr_v[BLK_W-1-8*DST -: 8] = sbox(st_in[BLK_W-1-8*SRC -: 8]);
    end
  end

  for (genvar c = 0; c < 4; c++) begin : g_mix
    logic [7:0] a0, a1, a2, a3;
    assign a0 = sr_v[BLK_W-1-32*c -: 8];
    assign a1 = sr_v[BLK_W-9-32*c -: 8];
    assign a2 = sr_v[BLK_W-17-32*c -: 8];
    assign a3 = sr_v[BLK_W-25-32*c -: 8];
    assign mc_v[BLK_W-1-32*c  -: 8] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
    assign mc_v[BLK_W-9-32*c  -: 8] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
    assign mc_v[BLK_W-17-32*c -: 8] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
    assign mc_v[BLK_W-25-32*c -: 8] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
  end

  assign st_out = (final_rnd ? sr_v : mc_v) ^ rk_in;
endmodule

// File: rtl/aes_key_sched.sv
module aes_key_sched
  import aes_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [BLK_W-1:0] key_in,
  input  logic [CNT_W-1:0] rd_idx,
  output logic [BLK_W-1:0] rd_key,
  output logic             busy,
  output logic             finish
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NR);
  localparam sched_t           ZERO_SCHED = expand_key('0);

  sched_t           sched_q, sched_d;
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       rcon_q, rcon_d;
  logic [CNT_W-1:0] prev_idx;
  logic [BLK_W-1:0] step_key;
  logic             sched_en;

  assign prev_idx = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
  assign step_key = key_step(sched_q[prev_idx], rcon_q);
  assign sched_en = go | busy_q;

  always_comb begin
    sched_d = sched_q;
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    rcon_d  = rcon_q;
    if (go) begin
      sched_d[0] = key_in;
      busy_d     = 1'b1;
      cnt_d      = CNT_W'(1);
      rcon_d     = 8'h01;
    end else if (busy_q) begin
      sched_d[cnt_q] = step_key;
      rcon_d         = xtime(rcon_q);
      cnt_d          = cnt_q + CNT_W'(1);
      if (cnt_q == LAST_CNT) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sched_q <= ZERO_SCHED;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      rcon_q  <= 8'h01;
    end else if (sched_en) begin
      sched_q <= sched_d;
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      rcon_q  <= rcon_d;
    end
  end

  assign busy   = busy_q;
  assign finish = busy_q && (cnt_q == LAST_CNT);
  assign rd_key = sched_q[rd_idx];

  assert_kdone_ends_R1: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy);
  assert_kbusy_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(finish));
endmodule

// File: rtl/aes_data_path.sv
module aes_data_path
  import aes_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [BLK_W-1:0] pt_in,
  input  logic [BLK_W-1:0] rk_in,
  output logic [CNT_W-1:0] rk_idx,
  output logic             busy,
  output logic             finish,
  output logic [BLK_W-1:0] ct_out,
  output logic             ct_valid
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NR);

  logic [BLK_W-1:0] st_q, st_d, rnd_out, ct_q, ct_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d, ctv_q, ctv_d;
  logic             last_rnd;

  assign last_rnd = (cnt_q == LAST_CNT);
  assign rk_idx   = busy_q ? cnt_q : '0;

  aes_round u_round (
    .st_in     (st_q),
    .rk_in     (rk_in),
    .final_rnd (last_rnd),
    .st_out    (rnd_out)
  );

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    ct_d   = ct_q;
    ctv_d  = 1'b0;
    if (go) begin
      st_d   = pt_in ^ rk_in;
      cnt_d  = CNT_W'(1);
      busy_d = 1'b1;
    end else if (busy_q) begin
      st_d  = rnd_out;
      cnt_d = cnt_q + CNT_W'(1);
      if (last_rnd) begin
        busy_d = 1'b0;
        ct_d   = rnd_out;
        ctv_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      ct_q   <= '0;
      ctv_q  <= 1'b0;
    end else begin
      if (go || busy_q) begin
        st_q   <= st_d;
        cnt_q  <= cnt_d;
        busy_q <= busy_d;
      end
      if (busy_q && last_rnd) ct_q <= ct_d;
      ctv_q <= ctv_d;
    end
  end

  assign busy     = busy_q;
  assign finish   = busy_q && last_rnd;
  assign ct_out   = ct_q;
  assign ct_valid = ctv_q;

  assert_ct_follows_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> ct_valid);
  assert_ct_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ct_valid |=> !ct_valid);
  assert_ct_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(ct_out));
endmodule

// File: rtl/aes128_enc_iter.sv
module aes128_enc_iter
  import aes_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_valid,
  input  logic [BLK_W-1:0] key_in,
  output logic             key_busy,
  output logic             key_done,
  input  logic             blk_valid,
  input  logic [BLK_W-1:0] blk_in,
  output logic             blk_busy,
  output logic             blk_done,
  output logic             ct_valid,
  output logic [BLK_W-1:0] ct_out
);
  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic             idle, key_go, blk_go;
  logic [CNT_W-1:0] rk_idx;
  logic [BLK_W-1:0] rk_val;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign idle   = !key_busy && !blk_busy;
  assign key_go = key_valid && idle;
  assign blk_go = blk_valid && idle && !key_valid;

  aes_key_sched u_ksched (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .go     (key_go),
    .key_in (key_in),
    .rd_idx (rk_idx),
    .rd_key (rk_val),
    .busy   (key_busy),
    .finish (key_done)
  );

  aes_data_path u_dpath (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .go       (blk_go),
    .pt_in    (blk_in),
    .rk_in    (rk_val),
    .rk_idx   (rk_idx),
    .busy     (blk_busy),
    .finish   (blk_done),
    .ct_out   (ct_out),
    .ct_valid (ct_valid)
  );

  assert_one_busy_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(key_busy && blk_busy));
  assert_blk_drop_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (blk_valid && key_busy) |=> !blk_busy);
  assert_key_first_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (key_valid && blk_valid && !key_busy && !blk_busy) |=> (key_busy && !blk_busy));
  assert_blk_start_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(blk_busy) |-> $past(blk_valid));
endmodule

// File: tb/aes128_enc_iter_bench.sv
module aes128_enc_iter_bench;
  localparam time CLK_P = 10;

  localparam logic [127:0] K_FIPS = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] P_FIPS = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C_FIPS = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] K_APX  = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] P_APX  = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] C_APX  = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [127:0] C_ZERO = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         key_valid, blk_valid;
  logic [127:0] key_in, blk_in;
  logic         key_busy, key_done, blk_busy, blk_done, ct_valid;
  logic [127:0] ct_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit all_done = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  aes128_enc_iter u_aes128_enc_iter (
    .clk(clk), .rst_n(rst_n),
    .key_valid(key_valid), .key_in(key_in), .key_busy(key_busy), .key_done(key_done),
    .blk_valid(blk_valid), .blk_in(blk_in), .blk_busy(blk_busy), .blk_done(blk_done),
    .ct_valid(ct_valid), .ct_out(ct_out)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; key_valid = 1'b0; blk_valid = 1'b0; key_in = '0; blk_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 busy/done/valid after reset",
        {124'd0, key_busy, key_done, blk_busy, blk_done}, '0);
    chk("R11 ct_valid after reset", {127'd0, ct_valid}, '0);
    chk("R11 ct_out after reset", ct_out, '0);
  endtask

  // key load with R1 timing; optional tamper of inputs during busy
  task automatic t_key_load(input logic [127:0] k, input bit tamper);
    @(negedge clk);
    key_valid = 1'b1; key_in = k;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      chk("R1 key_busy during load", {127'd0, key_busy}, 128'd1);
      chk("R1 key_done position", {127'd0, key_done}, {127'd0, (i == 10)});
      chk("R3 blk_busy stays low during key load", {127'd0, blk_busy}, '0);
      if (tamper && i < 9) begin
        key_valid = 1'b1; key_in = ~k;       // R2 / R3
        blk_valid = 1'b1; blk_in = ~k;
      end else begin
        key_valid = 1'b0; blk_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R1 key_busy low after load", {127'd0, key_busy}, '0);
    chk("R3 no block started by dropped request", {127'd0, blk_busy}, '0);
  endtask

  task automatic t_encrypt(input logic [127:0] pt, input logic [127:0] exp,
                           input bit tamper, input string tag);
    @(negedge clk);
    blk_valid = 1'b1; blk_in = pt;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      chk("R5 blk_busy during encryption", {127'd0, blk_busy}, 128'd1);
      chk("R5 blk_done position", {127'd0, blk_done}, {127'd0, (i == 10)});
      chk("R3 key_busy stays low during encryption", {127'd0, key_busy}, '0);
      blk_valid = 1'b0;
      if (tamper && i < 9) begin
        blk_in = ~pt;                         // R12
        key_valid = 1'b1; key_in = ~pt;       // R3
      end else begin
        key_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk({tag, " ct_valid in 11th cycle (R6)"}, {127'd0, ct_valid}, 128'd1);
    chk({tag, " ciphertext (R6)"}, ct_out, exp);
    chk("R3 key request during encryption dropped", {127'd0, key_busy}, '0);
    @(negedge clk);
    chk("R9 ct_valid one cycle", {127'd0, ct_valid}, '0);
    chk("R9 ct_out held", ct_out, exp);
  endtask

  task automatic t_back_to_back(input logic [127:0] pt, input logic [127:0] exp);
    @(negedge clk);
    blk_valid = 1'b1; blk_in = pt;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      blk_valid = 1'b0;
    end
    chk("R7 first blk_done seen", {127'd0, blk_done}, 128'd1);
    @(negedge clk);
    chk("R7 first ciphertext", ct_out, exp);
    blk_valid = 1'b1; blk_in = pt;            // the cycle right after done
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      blk_valid = 1'b0;
      chk("R7 second block accepted without gap", {127'd0, blk_busy}, 128'd1);
    end
    chk("R7 second blk_done", {127'd0, blk_done}, 128'd1);
    @(negedge clk);
    chk("R7 second ct_valid", {127'd0, ct_valid}, 128'd1);
    chk("R7 R8 second ciphertext with same key", ct_out, exp);
  endtask

  task automatic t_priority(input logic [127:0] prev_ct);
    @(negedge clk);
    key_valid = 1'b1; key_in = K_FIPS;
    blk_valid = 1'b1; blk_in = P_FIPS;
    @(negedge clk);
    key_valid = 1'b0; blk_valid = 1'b0;
    chk("R4 key load wins", {127'd0, key_busy}, 128'd1);
    chk("R4 block request dropped", {127'd0, blk_busy}, '0);
    repeat (10) @(negedge clk);
    chk("R4 idle after load", {126'd0, key_busy, blk_busy}, '0);
    chk("R9 ct_out held across key load", ct_out, prev_ct);
    t_encrypt(P_FIPS, C_FIPS, 1'b0, "R4 new key in use");
  endtask

  initial begin
    t_reset();
    t_encrypt('0, C_ZERO, 1'b0, "R10 reset key");
    t_key_load(K_FIPS, 1'b1);
    t_encrypt(P_FIPS, C_FIPS, 1'b1, "R2 R12 captured inputs");
    t_encrypt(P_FIPS, C_FIPS, 1'b0, "R8 key reused");
    t_key_load(K_APX, 1'b0);
    t_back_to_back(P_APX, C_APX);
    t_priority(C_APX);
    all_done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!all_done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule